// File: doc/BRIEF.md
# Bus-Attached Parallel I/O Port

This block is a slave on a simple synchronous processor bus made of an address bus, a write-data bus, a read-data bus, separate read and write strobes, and an I/O-versus-memory select line. It claims a four-register slot and links the processor to two external devices. An input device hands data in over a valid/ready pair. An output device takes data out over a valid/ready pair. A fourth register is a plain output latch whose value drives a set of pins.

A mode input selects the decoding scheme. In memory-mapped mode the whole address is compared, so the slot sits inside the top I/O window (0xFC00 and up) and never overlaps memory. In separate-I/O mode only the low address bits are compared, and the select line must mark the access as I/O. Every read enable and every latch load needs both a matching address and the matching strobe. Software can poll a ready flag in the status register. The port can also hold the bus cycle with a wait output until the input data exists or the output device has room.

Top module: `pio_bus_port`

## Requirements
- R1: With `mm_mode`=1, the port is selected only when `addr[15:2]` equals the memory-mapped base bits (default base 0xFC00, so 0xFC00..0xFC03). `io_m` is ignored, and any other address, inside or below the window, leaves the port silent.
- R2: With `mm_mode`=0, the port is selected only when `io_m`=1 and `addr[7:2]` equals the I/O base bits (default base 0x40, so 0x40..0x43). Bits 15:8 are ignored. With `io_m`=0, reads are not enabled and writes change nothing.
- R3: `addr[1:0]` picks the register. 0 is input data (read only). 1 is status: bit0 = data-ready, bit1 = output pending, other bits 0. 2 is output data, which can be read back. 3 is the auxiliary latch, which can be read back and drives `aux_out`.
- R4: `rd_oe` is 1 in the same cycle only when the port is selected and `rd`=1. Whenever `rd_oe`=0, `rd_data` is 0.
- R5: A latch loads `wdata` on the clock edge where the port is selected, `wr`=1 and `bus_wait`=0. The new value is visible after that edge.
- R6: `in_ready` equals the inverse of data-ready. An edge with `in_valid`=1 and `in_ready`=1 captures `in_data` and sets data-ready.
- R7: Reading register 0 while data-ready is 0 raises `bus_wait` in the same cycle. It drops in the cycle after input data is captured. The read then returns that data, and its completing edge clears data-ready.
- R8: Reading the status register changes no state.
- R9: A write to register 2 while `out_valid`=1 and `out_ready`=0 raises `bus_wait` and leaves `out_data` unchanged. Once `out_ready`=1, the wait drops and the write loads. `out_valid` holds with stable `out_data` until `out_ready` is seen.
- R10: A synchronous active-high `rst` clears `out_data`, `aux_out`, data-ready and `out_valid`, and holds `bus_wait` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| mm_mode | input | 1 | 1 = memory-mapped full decode, 0 = separate I/O reduced decode |
| addr | input | 16 | Processor address |
| io_m | input | 1 | 1 = I/O access, 0 = memory access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data from processor |
| rd_data | output | 8 | Read data, 0 when not enabled |
| rd_oe | output | 1 | Read data is being driven |
| bus_wait | output | 1 | Stretch the current bus cycle |
| in_valid | input | 1 | Input device offers data |
| in_data | input | 8 | Input device data |
| in_ready | output | 1 | Port can accept input data |
| out_valid | output | 1 | Output data pending for device |
| out_data | output | 8 | Output data latch |
| out_ready | input | 1 | Output device accepts data |
| aux_out | output | 8 | Auxiliary output latch |

## Verification
The bench aims at decode boundaries. It uses addresses just below the I/O window, other slots inside the window, I/O-space hits with junk in the upper bits, and accesses with the select line low. A decoder that compares too few bits would claim these cycles and corrupt the auxiliary latch. It runs reads that stall before input data arrives and writes that stall behind a pending output byte. A wrong stall would either return stale data, load the latch more than once, or overwrite a byte the device had not taken. It also reads the status register repeatedly, because a status read with side effects would clear the ready flag and lose a byte.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned REG_IDX_W = 2;
  localparam int unsigned REG_COUNT = 1 << REG_IDX_W;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_IN_DATA  = 2'd0,
    REG_STATUS   = 2'd1,
    REG_OUT_DATA = 2'd2,
    REG_AUX      = 2'd3
  } pio_reg_e;

  // Status word: bit0 data-ready, bit1 output pending, rest zero.
  function automatic logic [7:0] pack_status(input logic dready, input logic opend);
    pack_status = {6'd0, opend, dready};
  endfunction

endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RED_W  = 8,
  parameter logic [ADDR_W-1:0] MM_BASE = 16'hFC00,
  parameter logic [RED_W-1:0]  IO_BASE = 8'h40
) (
  input  logic clk,
  input  logic rst,
  input  logic mm_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic io_m,
  input  logic rd,
  input  logic wr,
  output logic sel,
  output logic [pio_pkg::REG_COUNT-1:0] rd_stb,
  output logic [pio_pkg::REG_COUNT-1:0] wr_stb
);
  import pio_pkg::*;

  logic mm_hit;
  logic io_hit;

  assign mm_hit = (addr[ADDR_W-1:REG_IDX_W] == MM_BASE[ADDR_W-1:REG_IDX_W]);
  assign io_hit = io_m && (addr[RED_W-1:REG_IDX_W] == IO_BASE[RED_W-1:REG_IDX_W]);
  assign sel    = mm_mode ? mm_hit : io_hit;

  for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_stb
    assign rd_stb[gi] = sel && rd && (addr[REG_IDX_W-1:0] == REG_IDX_W'(gi));
    assign wr_stb[gi] = sel && wr && (addr[REG_IDX_W-1:0] == REG_IDX_W'(gi));
  end

  // R2: memory accesses in separate-I/O mode never produce a strobe
  a_r2_silent_mem: assert property (@(posedge clk) disable iff (rst)
    (!mm_mode && !io_m) |-> (rd_stb == '0 && wr_stb == '0));
  // R3: at most one register strobed per direction
  a_r3_one_reg: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_stb) && $onehot0(wr_stb));

endmodule

// File: rtl/pio_in_chan.sv
module pio_in_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic in_ready,
  input  logic rd_req,
  output logic data_ready,
  output logic [DATA_W-1:0] buf_data,
  output logic stall
);
  logic capture;
  logic take;

  assign in_ready = !data_ready;
  assign capture  = in_valid && in_ready;
  assign stall    = rd_req && !data_ready;
  assign take     = rd_req && data_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      buf_data   <= '0;
    end else if (capture) begin
      data_ready <= 1'b1;
      buf_data   <= in_data;
    end else if (take) begin
      data_ready <= 1'b0;
    end
  end

  // R6: an accepted input sets the ready flag
  a_r6_capture_sets: assert property (@(posedge clk) disable iff (rst)
    capture |=> (data_ready && buf_data == $past(in_data)));
  // R7: a completed data read empties the buffer
  a_r7_take_clears: assert property (@(posedge clk) disable iff (rst)
    take |=> !data_ready);
  // R7: a stalled read never completes
  a_r7_stall_no_take: assert property (@(posedge clk) disable iff (rst)
    stall |-> !take);

endmodule

// File: rtl/pio_out_chan.sv
module pio_out_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_req,
  input  logic [DATA_W-1:0] wdata,
  input  logic out_ready,
  output logic out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic stall
);
  logic load;

  assign stall = wr_req && out_valid && !out_ready;
  assign load  = wr_req && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= wdata;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: pending data holds until the device takes it
  a_r9_hold_pending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !wr_req) |=> (out_valid && $stable(out_data)));
  // R9: a stalled write leaves the latch untouched
  a_r9_stall_keeps: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(out_data));

endmodule

// File: rtl/pio_bus_port.sv
module pio_bus_port #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RED_W  = 8,
  parameter logic [ADDR_W-1:0] MM_BASE = 16'hFC00,
  parameter logic [RED_W-1:0]  IO_BASE = 8'h40
) (
  input  logic clk,
  input  logic rst,
  input  logic mm_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic io_m,
  input  logic rd,
  input  logic wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic rd_oe,
  output logic bus_wait,
  input  logic in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic in_ready,
  output logic out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic out_ready,
  output logic [DATA_W-1:0] aux_out
);
  import pio_pkg::*;

  logic sel;
  logic [REG_COUNT-1:0] rd_stb;
  logic [REG_COUNT-1:0] wr_stb;
  logic data_ready;
  logic [DATA_W-1:0] in_buf;
  logic in_stall;
  logic out_stall;
  logic aux_load;
  logic [7:0] status_w;
  logic [DATA_W-1:0] mux_data;

  pio_addr_decode #(
    .ADDR_W(ADDR_W), .RED_W(RED_W), .MM_BASE(MM_BASE), .IO_BASE(IO_BASE)
  ) u_dec (
    .clk(clk), .rst(rst), .mm_mode(mm_mode), .addr(addr), .io_m(io_m),
    .rd(rd), .wr(wr), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  pio_in_chan #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_req(rd_stb[REG_IN_DATA]),
    .data_ready(data_ready), .buf_data(in_buf), .stall(in_stall)
  );

  pio_out_chan #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .wr_req(wr_stb[REG_OUT_DATA]), .wdata(wdata),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .stall(out_stall)
  );

  assign bus_wait = !rst && (in_stall || out_stall);
  assign aux_load = wr_stb[REG_AUX];
  assign status_w = pack_status(data_ready, out_valid);

  always_ff @(posedge clk) begin
    if (rst) aux_out <= '0;
    else if (aux_load) aux_out <= wdata;
  end

  always_comb begin
    unique case (pio_reg_e'(addr[REG_IDX_W-1:0]))
      REG_IN_DATA:  mux_data = in_buf;
      REG_STATUS:   mux_data = DATA_W'(status_w);
      REG_OUT_DATA: mux_data = out_data;
      REG_AUX:      mux_data = aux_out;
      default:      mux_data = '0;
    endcase
  end

  assign rd_oe   = |rd_stb;
  assign rd_data = rd_oe ? mux_data : '0;

  // R4: read enable needs the read strobe
  a_r4_oe_needs_rd: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> rd);
  // R4: idle read bus is zero
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_oe |-> (rd_data == '0));
  // R5: auxiliary latch takes the write data on an accepted write
  a_r5_aux_load: assert property (@(posedge clk) disable iff (rst)
    aux_load |=> (aux_out == $past(wdata)));
  // R5: without a write strobe the auxiliary latch holds
  a_r5_aux_hold: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(aux_out));
  // R7: wait implies an active strobe
  a_r7_wait_strobe: assert property (@(posedge clk) disable iff (rst)
    bus_wait |-> (rd || wr));

endmodule

// File: tb/pio_bus_port_tb.sv
module pio_bus_port_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mm_mode = 1'b1;
  logic [15:0] addr = '0;
  logic io_m = 1'b0;
  logic rd = 1'b0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic rd_oe;
  logic bus_wait;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic out_valid;
  logic [7:0] out_data;
  logic out_ready = 1'b0;
  logic [7:0] aux_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pio_bus_port dut_i (
    .clk(clk), .rst(rst), .mm_mode(mm_mode), .addr(addr), .io_m(io_m),
    .rd(rd), .wr(wr), .wdata(wdata), .rd_data(rd_data), .rd_oe(rd_oe),
    .bus_wait(bus_wait), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .aux_out(aux_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic r, input logic w,
                     input logic [7:0] d, input logic iom);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d; io_m = iom;
    #2;
  endtask

  task automatic idle();
    bus(16'h0000, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic write_cycle(input logic [15:0] a, input logic [7:0] d, input logic iom);
    bus(a, 1'b0, 1'b1, d, iom);
    @(posedge clk);
    idle();
  endtask

  task automatic read_chk(input string tag, input logic [15:0] a, input logic iom,
                          input logic oe_exp, input logic [7:0] d_exp);
    bus(a, 1'b1, 1'b0, 8'h00, iom);
    chk({tag, " oe"}, 16'(rd_oe), 16'(oe_exp));
    chk({tag, " data"}, 16'(rd_data), 16'(d_exp));
    @(posedge clk);
    idle();
  endtask

  task automatic t_reset();
    // R10: cleared state after reset
    chk("R10 out_valid", 16'(out_valid), 16'h0);
    chk("R10 aux_out", 16'(aux_out), 16'h0);
    chk("R10 out_data", 16'(out_data), 16'h0);
    chk("R10 in_ready", 16'(in_ready), 16'h1);
    chk("R10 wait", 16'(bus_wait), 16'h0);
    chk("R4 idle oe", 16'(rd_oe), 16'h0);
  endtask

  task automatic t_mm_decode();
    mm_mode = 1'b1;
    write_cycle(16'hFC03, 8'h5A, 1'b0);
    chk("R5 aux load", 16'(aux_out), 16'h5A);
    read_chk("R1 R3 aux readback", 16'hFC03, 1'b0, 1'b1, 8'h5A);
    write_cycle(16'hFB03, 8'hFF, 1'b1);
    write_cycle(16'hFD03, 8'hEE, 1'b0);
    write_cycle(16'h0043, 8'hDD, 1'b1);
    chk("R1 aux untouched", 16'(aux_out), 16'h5A);
    read_chk("R1 below window", 16'hFB03, 1'b0, 1'b0, 8'h00);
    read_chk("R1 other slot", 16'hFC07, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic t_sep_decode();
    mm_mode = 1'b0;
    write_cycle(16'hAB43, 8'h3C, 1'b1);
    chk("R2 upper ignored", 16'(aux_out), 16'h3C);
    read_chk("R2 io read", 16'h0043, 1'b1, 1'b1, 8'h3C);
    write_cycle(16'h0043, 8'h99, 1'b0);
    chk("R2 mem write ignored", 16'(aux_out), 16'h3C);
    read_chk("R2 mem read silent", 16'h0043, 1'b0, 1'b0, 8'h00);
    read_chk("R2 io miss", 16'h0047, 1'b1, 1'b0, 8'h00);
    mm_mode = 1'b1;
  endtask

  task automatic t_oe_gate();
    bus(16'hFC03, 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R4 no rd oe", 16'(rd_oe), 16'h0);
    chk("R4 no rd data", 16'(rd_data), 16'h0);
    idle();
  endtask

  task automatic t_input_poll();
    read_chk("R3 status empty", 16'hFC01, 1'b0, 1'b1, 8'h00);
    @(negedge clk); in_valid = 1'b1; in_data = 8'hA7;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0; #2;
    chk("R6 in_ready low", 16'(in_ready), 16'h0);
    read_chk("R8 status first", 16'hFC01, 1'b0, 1'b1, 8'h01);
    read_chk("R8 status again", 16'hFC01, 1'b0, 1'b1, 8'h01);
    bus(16'hFC00, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R7 no wait when ready", 16'(bus_wait), 16'h0);
    chk("R3 input data", 16'(rd_data), 16'h00A7);
    @(posedge clk);
    idle();
    chk("R7 cleared", 16'(in_ready), 16'h1);
    read_chk("R7 status cleared", 16'hFC01, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic t_input_wait();
    bus(16'hFC00, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R7 wait raised", 16'(bus_wait), 16'h1);
    repeat (2) @(posedge clk);
    @(negedge clk); #2;
    chk("R7 wait held", 16'(bus_wait), 16'h1);
    @(negedge clk); in_valid = 1'b1; in_data = 8'h3E;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0; #2;
    chk("R7 wait dropped", 16'(bus_wait), 16'h0);
    chk("R7 waited data", 16'(rd_data), 16'h003E);
    @(posedge clk);
    idle();
    read_chk("R7 status after", 16'hFC01, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic t_output();
    out_ready = 1'b0;
    write_cycle(16'hFC02, 8'h11, 1'b0);
    chk("R9 valid", 16'(out_valid), 16'h1);
    chk("R9 data first", 16'(out_data), 16'h11);
    read_chk("R3 status pending", 16'hFC01, 1'b0, 1'b1, 8'h02);
    bus(16'hFC02, 1'b0, 1'b1, 8'h22, 1'b0);
    chk("R9 wait on full", 16'(bus_wait), 16'h1);
    repeat (2) @(posedge clk);
    @(negedge clk); #2;
    chk("R9 data kept", 16'(out_data), 16'h11);
    out_ready = 1'b1; #1;
    chk("R9 wait released", 16'(bus_wait), 16'h0);
    @(posedge clk);
    idle();
    chk("R9 second data", 16'(out_data), 16'h22);
    chk("R9 still valid", 16'(out_valid), 16'h1);
    @(posedge clk);
    @(negedge clk); #2;
    chk("R9 drained", 16'(out_valid), 16'h0);
    out_ready = 1'b0;
    read_chk("R3 out readback", 16'hFC02, 1'b0, 1'b1, 8'h22);
  endtask

  task automatic t_midrun_reset();
    write_cycle(16'hFC03, 8'h77, 1'b0);
    write_cycle(16'hFC02, 8'h55, 1'b0);
    @(negedge clk); in_valid = 1'b1; in_data = 8'h12;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0; #2;
    chk("R10 aux cleared", 16'(aux_out), 16'h0);
    chk("R10 out cleared", 16'(out_data), 16'h0);
    chk("R10 valid cleared", 16'(out_valid), 16'h0);
    chk("R10 ready flag cleared", 16'(in_ready), 16'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #2;
    t_reset();
    t_mm_decode();
    t_sep_decode();
    t_oe_gate();
    t_input_poll();
    t_input_wait();
    t_output();
    t_midrun_reset();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule